// File: doc/BRIEF.md
# Dual-Rate Frame Staging Write Controller

This block takes two upstream frame streams that share one clock: a wide stream that carries 64-bit beats and a narrow stream that carries 8-bit beats. Each beat comes with a valid strobe and an end-of-frame flag. Each stream has its own packer that gathers beats into 256-bit words. A word closes when it is full or when its frame ends. A round-robin arbiter places the finished words from both packers into one shared staging buffer. Every staged word carries a source tag, a byte count and an end-of-frame flag.

A write controller drains the staging buffer towards an external memory port with a valid/ready handshake. It starts a write only after more than 1024 bytes of frame data have gathered. Each such write is one burst of exactly 32 words. Because of this, a steady run of short frames is written as large bursts and never as a stream of small writes. A programmable idle timeout flushes data left below the threshold, so that no frame waits forever. When the staging buffer is full, the packers stop taking beats through their ready outputs, and no beat is lost.

Top module: `dual_rate_stager`

## Requirements
- R1: A wide-stream word holds up to 4 beats. Beat k sits at bits [64k+63:64k]. The word closes after the 4th beat or at end of frame. Its byte count is 8 times the number of beats it holds, and its unfilled bits are zero.
- R2: A narrow-stream word holds up to 32 bytes. Byte k sits at bits [8k+7:8k]. The word closes after the 32nd byte or at end of frame. Its byte count is the number of bytes it holds, and its unfilled bits are zero.
- R3: Every word at the memory port shows mem_src (0 = wide, 1 = narrow), its byte count and mem_eof. The eof flag is 1 only on the word that holds the last beat of a frame. The words of each source leave in the order in which they arrived.
- R4: No memory burst begins while the staged byte count is 1024 or less, unless an idle flush starts it. A run of back-to-back 64-byte frames that adds up to exactly 1024 bytes produces no memory write before the idle timeout.
- R5: A burst started by the threshold moves exactly 32 words, with mem_last high on the 32nd word only. The staged byte count drops by the bytes of every word moved.
- R6: When both packers hold a finished word and the buffer has room, the two sources are granted in turn. No source is granted twice in a row while the other one waits.
- R7: When idle_limit is nonzero, staged data is present and no input beat has been accepted for idle_limit cycles, a flush burst of min(staged words, 32) words is issued.
- R8: When the staging buffer is full, no word is written into it. The packers then drop ready, and every accepted beat eventually reaches the memory port.
- R9: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_data, mem_src, mem_bytes, mem_eof and mem_last stay stable.
- R10: After reset, mem_valid is low and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_limit | input | 16 | Idle cycles before a flush; 0 turns flushing off |
| wide_valid | input | 1 | Wide beat valid |
| wide_data | input | 64 | Wide beat data |
| wide_eof | input | 1 | Wide beat is the last of its frame |
| wide_ready | output | 1 | Wide beat accepted when high with valid |
| nar_valid | input | 1 | Narrow beat valid |
| nar_data | input | 8 | Narrow beat data |
| nar_eof | input | 1 | Narrow beat is the last of its frame |
| nar_ready | output | 1 | Narrow beat accepted when high with valid |
| mem_valid | output | 1 | Memory write word valid |
| mem_ready | input | 1 | Memory port accepts the word |
| mem_data | output | 256 | Staged word |
| mem_src | output | 1 | Source tag, 0 wide, 1 narrow |
| mem_bytes | output | 6 | Valid bytes in the word |
| mem_eof | output | 1 | Word ends a frame |
| mem_last | output | 1 | Last word of the current burst |

## Verification
The first pattern is a run of 64-byte wide frames that adds up to exactly 1024 bytes. It shows the block holding back writes, and one extra 5-byte narrow frame then shows the threshold burst of 32 words and the later idle flush of the single leftover word. The second pattern keeps the memory port stalled while both streams keep sending. It fills the buffer, so the bench can separate correct backpressure from silent loss or reordering. The third pattern runs both streams at once with odd frame lengths (1, 31, 32, 33 and 40 bytes; 3 and 5 beats). It tests partial-word byte counts, the end-of-frame placement and the round-robin fairness under contention.

// File: rtl/dr_stage_pkg.sv
package dr_stage_pkg;

  typedef enum logic [0:0] {WC_IDLE = 1'b0, WC_BURST = 1'b1} wc_state_t;

  // Round-robin pick: returns 1 when narrow (b) wins; last_b = narrow won last time
  function automatic logic rr_pick_b(input logic last_b, input logic req_a, input logic req_b);
    return req_b && (!req_a || !last_b);
  endfunction

endpackage

// File: rtl/dr_packer.sv
module dr_packer #(
  parameter int IN_W   = 64,
  parameter int WORD_W = 256,
  localparam int BEATS  = WORD_W / IN_W,
  localparam int IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int BYTE_W = $clog2(WORD_W / 8 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              word_full,
  output logic [WORD_W-1:0] word_data,
  output logic [BYTE_W-1:0] word_bytes,
  output logic              word_eof,
  input  logic              word_pop
);

  function automatic logic [BYTE_W-1:0] bytes_for(input logic [IDX_W-1:0] idx);
    return BYTE_W'((int'(idx) + 1) * (IN_W / 8));
  endfunction

  logic [WORD_W-1:0] buf_q, base;
  logic [IDX_W-1:0]  idx_q;
  logic              accept, closes;

  assign in_ready = !word_full || word_pop;
  assign accept   = in_valid && in_ready;
  assign closes   = (int'(idx_q) == BEATS - 1) || in_eof;

  always_comb begin
    base = word_full ? '0 : buf_q;
    base[int'(idx_q) * IN_W +: IN_W] = in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q      <= '0;
      idx_q      <= '0;
      word_full  <= 1'b0;
      word_bytes <= '0;
      word_eof   <= 1'b0;
    end else if (accept) begin
      buf_q <= base;
      if (closes) begin
        idx_q      <= '0;
        word_full  <= 1'b1;
        word_bytes <= bytes_for(idx_q);
        word_eof   <= in_eof;
      end else begin
        idx_q     <= idx_q + 1'b1;
        word_full <= 1'b0;
      end
    end else if (word_pop) begin
      buf_q     <= '0;
      word_full <= 1'b0;
    end
  end

  assign word_data = buf_q;

endmodule

// File: rtl/dr_stage_fifo.sv
module dr_stage_fifo #(
  parameter int ENTRY_W = 264,
  parameter int DEPTH   = 64,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ENTRY_W-1:0] din,
  input  logic               pop,
  output logic [ENTRY_W-1:0] dout,
  output logic [CNT_W-1:0]   fill,
  output logic               full
);

  logic [ENTRY_W-1:0] store_q [DEPTH];
  logic [PTR_W-1:0]   wr_q, rd_q;

  assign full = (fill == CNT_W'(DEPTH));
  assign dout = store_q[rd_q];

  always_ff @(posedge clk) begin
    if (push) store_q[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
      fill <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
      fill <= fill + CNT_W'(push) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/dr_write_ctrl.sv
module dr_write_ctrl
  import dr_stage_pkg::*;
#(
  parameter int WORD_BYTES   = 32,
  parameter int BURST_WORDS  = 32,
  parameter int THRESH_BYTES = 1024,
  parameter int DEPTH        = 64,
  parameter int IDLE_W       = 16,
  localparam int SB_W   = $clog2(DEPTH * WORD_BYTES + 1),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int BYTE_W = $clog2(WORD_BYTES + 1),
  localparam int REM_W  = $clog2(BURST_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_bytes,
  input  logic              pop,
  input  logic [BYTE_W-1:0] pop_bytes,
  input  logic [CNT_W-1:0]  fill,
  input  logic              in_beat,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              mem_valid,
  output logic              mem_last,
  output logic              flush_mode,
  output logic              thresh_hit,
  output logic              flush_hit,
  output logic [SB_W-1:0]   staged_bytes
);

  function automatic logic [SB_W-1:0] next_staged(input logic [SB_W-1:0] cur,
      input logic add_en, input logic [BYTE_W-1:0] add,
      input logic sub_en, input logic [BYTE_W-1:0] sub);
    return cur + (add_en ? SB_W'(add) : '0) - (sub_en ? SB_W'(sub) : '0);
  endfunction

  function automatic logic [REM_W-1:0] flush_len(input logic [CNT_W-1:0] n);
    return (int'(n) > BURST_WORDS) ? REM_W'(BURST_WORDS) : REM_W'(n);
  endfunction

  wc_state_t         state_q;
  logic [REM_W-1:0]  remain_q;
  logic [IDLE_W-1:0] idle_q;

  assign thresh_hit = staged_bytes > SB_W'(THRESH_BYTES);
  assign flush_hit  = (idle_limit != '0) && (idle_q >= idle_limit) && (fill != '0);
  assign mem_valid  = (state_q == WC_BURST);
  assign mem_last   = mem_valid && (remain_q == REM_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_bytes <= '0;
      idle_q       <= '0;
    end else begin
      staged_bytes <= next_staged(staged_bytes, push, push_bytes, pop, pop_bytes);
      if (in_beat) idle_q <= '0;
      else if (idle_q != '1) idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= WC_IDLE;
      remain_q   <= '0;
      flush_mode <= 1'b0;
    end else if (state_q == WC_IDLE) begin
      if (thresh_hit) begin
        state_q    <= WC_BURST;
        remain_q   <= REM_W'(BURST_WORDS);
        flush_mode <= 1'b0;
      end else if (flush_hit) begin
        state_q    <= WC_BURST;
        remain_q   <= flush_len(fill);
        flush_mode <= 1'b1;
      end
    end else if (pop) begin
      remain_q <= remain_q - 1'b1;
      if (remain_q == REM_W'(1)) state_q <= WC_IDLE;
    end
  end

endmodule

// File: rtl/dual_rate_stager.sv
module dual_rate_stager
  import dr_stage_pkg::*;
#(
  parameter int WIDE_W       = 64,
  parameter int NAR_W        = 8,
  parameter int WORD_W       = 256,
  parameter int DEPTH        = 64,
  parameter int BURST_WORDS  = 32,
  parameter int THRESH_BYTES = 1024,
  parameter int IDLE_W       = 16,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int BYTE_W     = $clog2(WORD_BYTES + 1),
  localparam int ENTRY_W    = WORD_W + BYTE_W + 2,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int SB_W       = $clog2(DEPTH * WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              wide_valid,
  input  logic [WIDE_W-1:0] wide_data,
  input  logic              wide_eof,
  output logic              wide_ready,
  input  logic              nar_valid,
  input  logic [NAR_W-1:0]  nar_data,
  input  logic              nar_eof,
  output logic              nar_ready,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [WORD_W-1:0] mem_data,
  output logic              mem_src,
  output logic [BYTE_W-1:0] mem_bytes,
  output logic              mem_eof,
  output logic              mem_last
);

  // Named internal events (observed by the checker)
  logic              req_w, req_n, grant_w, grant_n, push, pop, buf_full;
  logic              rr_last_n, flush_mode, thresh_hit, flush_hit, in_beat;
  logic [SB_W-1:0]   staged_bytes;
  logic [CNT_W-1:0]  fill;

  logic [WORD_W-1:0] w_data, n_data;
  logic [BYTE_W-1:0] w_bytes, n_bytes;
  logic              w_eof, n_eof;
  logic [ENTRY_W-1:0] push_entry, head;
  logic              pick_n;

  dr_packer #(.IN_W(WIDE_W), .WORD_W(WORD_W)) u_pack_w (
    .clk, .rst_n, .in_valid(wide_valid), .in_data(wide_data), .in_eof(wide_eof),
    .in_ready(wide_ready), .word_full(req_w), .word_data(w_data),
    .word_bytes(w_bytes), .word_eof(w_eof), .word_pop(grant_w));

  dr_packer #(.IN_W(NAR_W), .WORD_W(WORD_W)) u_pack_n (
    .clk, .rst_n, .in_valid(nar_valid), .in_data(nar_data), .in_eof(nar_eof),
    .in_ready(nar_ready), .word_full(req_n), .word_data(n_data),
    .word_bytes(n_bytes), .word_eof(n_eof), .word_pop(grant_n));

  assign pick_n  = rr_pick_b(rr_last_n, req_w, req_n);
  assign grant_n = !buf_full && pick_n;
  assign grant_w = !buf_full && req_w && !pick_n;
  assign push    = grant_w || grant_n;
  assign in_beat = (wide_valid && wide_ready) || (nar_valid && nar_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) rr_last_n <= 1'b0;
    else if (push) rr_last_n <= grant_n;
  end

  // Entry layout: {eof, src, bytes, data}
  assign push_entry = grant_n ? {n_eof, 1'b1, n_bytes, n_data}
                              : {w_eof, 1'b0, w_bytes, w_data};

  dr_stage_fifo #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_stage (
    .clk, .rst_n, .push, .din(push_entry), .pop, .dout(head), .fill, .full(buf_full));

  assign pop = mem_valid && mem_ready;
  assign {mem_eof, mem_src, mem_bytes, mem_data} = head;

  dr_write_ctrl #(.WORD_BYTES(WORD_BYTES), .BURST_WORDS(BURST_WORDS),
                  .THRESH_BYTES(THRESH_BYTES), .DEPTH(DEPTH), .IDLE_W(IDLE_W)) u_wctl (
    .clk, .rst_n, .push, .push_bytes(push_entry[WORD_W +: BYTE_W]), .pop,
    .pop_bytes(mem_bytes), .fill, .in_beat, .idle_limit, .mem_valid, .mem_last,
    .flush_mode, .thresh_hit, .flush_hit, .staged_bytes);

endmodule

// File: rtl/dual_rate_stager_chk.sv
module dual_rate_stager_chk #(
  parameter int BURST_WORDS = 32,
  parameter int WORD_W      = 256,
  parameter int BYTE_W      = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_last,
  input logic [WORD_W-1:0] mem_data,
  input logic [BYTE_W-1:0] mem_bytes,
  input logic              mem_src,
  input logic              flush_mode,
  input logic              thresh_hit,
  input logic              flush_hit,
  input logic              buf_full,
  input logic              push,
  input logic              req_w,
  input logic              req_n,
  input logic              grant_w,
  input logic              grant_n
);

  localparam int BC_W = $clog2(BURST_WORDS + 1);
  logic [BC_W-1:0] beat_cnt;
  logic            hs;

  assign hs = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) beat_cnt <= '0;
    else if (hs) beat_cnt <= mem_last ? '0 : beat_cnt + 1'b1;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data) && $stable(mem_bytes)
                                   && $stable(mem_src) && $stable(mem_last)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !push);

  assert_rr_turn_w_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_w && req_n) |=> !grant_w);

  assert_rr_turn_n_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_n && req_w) |=> !grant_n);

  assert_start_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(thresh_hit || flush_hit));

  assert_burst_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (int'(beat_cnt) < BURST_WORDS));

  assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && mem_last && !flush_mode) |-> (int'(beat_cnt) == BURST_WORDS - 1));

endmodule

bind dual_rate_stager dual_rate_stager_chk #(
  .BURST_WORDS(BURST_WORDS), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (
  .clk, .rst_n, .mem_valid, .mem_ready, .mem_last, .mem_data, .mem_bytes, .mem_src,
  .flush_mode, .thresh_hit, .flush_hit, .buf_full, .push, .req_w, .req_n,
  .grant_w, .grant_n);

// File: tb/dual_rate_stager_tb_top.sv
module dual_rate_stager_tb_top;

  typedef struct {
    logic [255:0] d;
    int           bytes;
    bit           eof;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  idle_limit = 16'd64;
  logic         wide_valid = 1'b0, wide_eof = 1'b0, nar_valid = 1'b0, nar_eof = 1'b0;
  logic [63:0]  wide_data = '0;
  logic [7:0]   nar_data = '0;
  logic         wide_ready, nar_ready, mem_valid, mem_src, mem_eof, mem_last;
  logic         mem_ready = 1'b1;
  logic [255:0] mem_data;
  logic [5:0]   mem_bytes;

  int checks = 0, errors = 0, cyc = 0;
  int hs_count = 0, cur_len = 0, last_in_cyc = 0, flush_cyc = 0;
  bit saw_stall = 0, phase1 = 0;
  exp_t qw[$], qn[$];
  int   blen[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_rate_stager dut_i (
    .clk, .rst_n, .idle_limit, .wide_valid, .wide_data, .wide_eof, .wide_ready,
    .nar_valid, .nar_data, .nar_eof, .nar_ready, .mem_valid, .mem_ready, .mem_data,
    .mem_src, .mem_bytes, .mem_eof, .mem_last);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_wide(input int nb, input int seed);
    logic [255:0] acc;
    logic [63:0]  beat;
    int           lane;
    acc = '0; lane = 0;
    for (int b = 0; b < nb; b++) begin
      beat = {16'(seed), 16'(b), 32'(seed * 131 + b * 7 + 1)};
      @(negedge clk);
      wide_valid = 1'b1; wide_data = beat; wide_eof = (b == nb - 1);
      #1;
      while (!wide_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      acc[lane * 64 +: 64] = beat; lane++;
      if (lane == 4 || b == nb - 1) begin
        qw.push_back('{acc, lane * 8, b == nb - 1});
        acc = '0; lane = 0;
      end
    end
    @(negedge clk); wide_valid = 1'b0; wide_eof = 1'b0;
  endtask

  task automatic send_nar(input int nb, input int seed);
    logic [255:0] acc;
    logic [7:0]   by;
    int           lane;
    acc = '0; lane = 0;
    for (int b = 0; b < nb; b++) begin
      by = 8'(seed + b * 7 + 3);
      @(negedge clk);
      nar_valid = 1'b1; nar_data = by; nar_eof = (b == nb - 1);
      #1;
      while (!nar_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      last_in_cyc = cyc;
      acc[lane * 8 +: 8] = by; lane++;
      if (lane == 32 || b == nb - 1) begin
        qn.push_back('{acc, lane, b == nb - 1});
        acc = '0; lane = 0;
      end
    end
    @(negedge clk); nar_valid = 1'b0; nar_eof = 1'b0;
  endtask

  // Monitor / scoreboard: samples 2 ns before the rising edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk); #8;
      if (!wide_ready) saw_stall = 1;
      if (rst_n && mem_valid && mem_ready) begin
        hs_count++;
        cur_len++;
        if (mem_src && phase1) flush_cyc = cyc;
        if ((mem_src ? qn.size() : qw.size()) == 0) begin
          chk(0, "R3", "unexpected word from source", 256'(mem_src), 0);
        end else begin
          e = mem_src ? qn.pop_front() : qw.pop_front();
          chk(mem_data == e.d, mem_src ? "R2" : "R1", "word data", mem_data, e.d);
          chk(int'(mem_bytes) == e.bytes, "R3", "byte count", 256'(mem_bytes), 256'(e.bytes));
          chk(mem_eof == e.eof, "R3", "eof flag", 256'(mem_eof), 256'(e.eof));
        end
        if (mem_last) begin
          chk(cur_len >= 1 && cur_len <= 32, "R5", "burst length bound", 256'(cur_len), 32);
          blen.push_back(cur_len);
          cur_len = 0;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(mem_valid == 0, "R10", "mem_valid after reset", 256'(mem_valid), 0);
    chk(wide_ready == 1, "R10", "wide_ready after reset", 256'(wide_ready), 1);
    chk(nar_ready == 1, "R10", "nar_ready after reset", 256'(nar_ready), 1);
    @(negedge clk); rst_n = 1'b1;

    // Phase 1: 16 back-to-back 64-byte frames = 1024 bytes, then one 5-byte frame
    for (int f = 0; f < 16; f++) send_wide(8, f + 1);
    repeat (40) @(negedge clk);
    chk(hs_count == 0, "R4", "writes at exactly 1024 bytes", 256'(hs_count), 0);
    phase1 = 1;
    send_nar(5, 9);
    repeat (150) @(negedge clk);
    phase1 = 0;
    chk(blen.size() == 2, "R5", "burst count phase 1", 256'(blen.size()), 2);
    if (blen.size() == 2) begin
      chk(blen[0] == 32, "R5", "threshold burst length", 256'(blen[0]), 32);
      chk(blen[1] == 1, "R7", "flush burst length", 256'(blen[1]), 1);
    end
    chk(flush_cyc - last_in_cyc >= 60 && flush_cyc - last_in_cyc <= 80, "R7",
        "flush delay after last beat", 256'(flush_cyc - last_in_cyc), 64);
    chk(qw.size() == 0 && qn.size() == 0, "R4", "phase 1 drained",
        256'(qw.size() + qn.size()), 0);

    // Phase 2: memory stalled, both streams push past buffer depth
    @(negedge clk); mem_ready = 1'b0; saw_stall = 0;
    fork
      for (int f = 0; f < 40; f++) send_wide(8, 100 + f);
      for (int f = 0; f < 4; f++) send_nar(40, 50 + f);
      begin
        repeat (700) @(negedge clk);
        chk(saw_stall == 1, "R8", "ready dropped while full", 256'(saw_stall), 1);
        mem_ready = 1'b1;
      end
    join
    repeat (300) @(negedge clk);
    chk(qw.size() == 0 && qn.size() == 0, "R8", "no lost words after stall",
        256'(qw.size() + qn.size()), 0);

    // Phase 3: contention with odd frame lengths, intermittent stalls
    fork
      begin
        send_nar(1, 7); send_nar(31, 8); send_nar(32, 9); send_nar(33, 10); send_nar(40, 11);
      end
      begin
        for (int f = 0; f < 12; f++) begin send_wide(3, 200 + f); send_wide(5, 300 + f); end
      end
      begin
        for (int k = 0; k < 30; k++) begin
          repeat (7) @(negedge clk); mem_ready = 1'b0;
          repeat (3) @(negedge clk); mem_ready = 1'b1;
        end
      end
    join
    repeat (300) @(negedge clk);
    chk(qw.size() == 0, "R6", "wide words all delivered under contention", 256'(qw.size()), 0);
    chk(qn.size() == 0, "R6", "narrow words all delivered under contention", 256'(qn.size()), 0);
    chk(mem_valid == 0, "R7", "idle after final flush", 256'(mem_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule